// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers single-cycle event pulses from three groups of sources into three 8-bit sticky status registers: two serve channel events and one serves port events. Each status register has a mask register of the same width. A set mask bit keeps the matching status bit out of the interrupt request, but the event is still latched. A summary register cannot be masked. It shows which status registers hold at least one pending bit whose mask bit is clear.

Software reads the registers through a simple strobe port. Reading a status register returns its contents and clears it on the same clock edge, and this also removes its summary bit. The single interrupt request output is registered and stays high while any summary bit is set.

Top module: `irq_status_agg`

Address map: 0 = channel A status, 1 = channel B status, 2 = port status, 3 = summary, 4 = channel A mask, 5 = channel B mask, 6 = port mask, 7 = unused.

## Requirements
- R1: After reset all status registers read 0, all mask registers read 0xFF, the summary reads 0 and `irq` is low.
- R2: An event pulse on bit b of a group sets status bit b on that clock edge. The bit then stays set until its register is read.
- R3: A read (`rd_en`) of address 0, 1 or 2 returns the register's current value on `rdata` in the same cycle and clears the register on that clock edge.
- R4: If an event arrives in the same cycle as a clearing read of its register, the event's bit is set after the edge.
- R5: A write (`wr_en`) to address 4, 5 or 6 loads `wdata` into the matching mask on that edge. The mask reads back at the same address, and a mask changes only when its own address is written.
- R6: Events whose mask bit is set are still latched in status. They leave the summary bit and `irq` unchanged.
- R7: Reading address 3 returns the summary: bit i is 1 when status register i ANDed with the inverse of its mask is nonzero. Bits 7:3 read 0, and reading address 3 clears nothing.
- R8: `irq` is active-high and registered. It is high exactly one cycle after the summary is nonzero and low one cycle after the summary is zero.
- R9: Clearing the mask bit of an already latched status bit sets the summary bit in the cycle after the write, and `irq` one cycle later.
- R10: Address 7 reads 0. Writes to addresses 0 to 3 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ch_a | input | 8 | Event pulses, channel A group |
| ev_ch_b | input | 8 | Event pulses, channel B group |
| ev_port | input | 8 | Event pulses, port group |
| rd_en | input | 1 | Read strobe; clears addressed status register |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Registered interrupt request, active-high |

## Verification
The read data belongs to the cycle of the read: it shows register state before the edge that applies the clear. Status and mask updates become visible one edge after their stimulus, the summary follows the same edge combinationally, and `irq` follows one edge later. The bench therefore drives inputs just after the falling edge and checks `rdata` before the next rising edge. It checks `irq` after that rising edge against a model whose request value is taken from the previous cycle's summary. Besides random mixes of events, reads and mask writes, directed steps cover latching while masked, unmasking, an event that meets a clearing read, and writes to read-only addresses.

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_ch_a,
  input  logic [W-1:0] ev_ch_b,
  input  logic [W-1:0] ev_port,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);
  localparam int NGRP = 3;
  localparam logic [2:0] A_SUM = 3'd3;
  localparam logic [2:0] A_MSK = 3'd4;

  logic [W-1:0] ev   [NGRP];
  logic [W-1:0] stat [NGRP];
  logic [W-1:0] mask [NGRP];
  logic [NGRP-1:0] summ;

  assign ev[0] = ev_ch_a;
  assign ev[1] = ev_ch_b;
  assign ev[2] = ev_port;

  always_comb
    for (int i = 0; i < NGRP; i++) summ[i] = |(stat[i] & ~mask[i]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      for (int i = 0; i < NGRP; i++) begin
        stat[i] <= '0;
        mask[i] <= '1;
      end
    end else begin
      irq <= |summ;
      for (int i = 0; i < NGRP; i++) begin
        stat[i] <= (rd_en && addr == 3'(i)) ? ev[i] : (stat[i] | ev[i]);
        if (wr_en && addr == A_MSK + 3'(i)) mask[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < 3'(NGRP))             rdata = stat[addr];
    else if (addr == A_SUM)          rdata = W'(summ);
    else if (addr < A_MSK + 3'(NGRP)) rdata = mask[addr - A_MSK];
  end

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_chk
      AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[g] != '0) |=> ((stat[g] & $past(ev[g])) == $past(ev[g]))); // R4
      AST_STICKY_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == 3'(g)) |=> ((stat[g] & $past(stat[g])) == $past(stat[g]))); // R2
      AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'(g) && ev[g] == '0) |=> (stat[g] == '0)); // R3
      AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_MSK + 3'(g)) |=> $stable(mask[g])); // R5
    end
  endgenerate

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (summ == '0) |=> !irq); // R6
  AST_SUMMARY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_SUM) |-> (rdata[W-1:NGRP] == '0)); // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd7) |-> (rdata == '0)); // R10
endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
  localparam time HALF = 4ns;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] ev_ch_a = '0, ev_ch_b = '0, ev_port = '0, wdata = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] rdata;
  logic irq;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_stat [3];
  logic [7:0] m_mask [3];
  logic       m_irq;

  always #HALF clk = ~clk;

  irq_status_agg dut (
    .clk(clk), .rst_n(rst_n), .ev_ch_a(ev_ch_a), .ev_ch_b(ev_ch_b), .ev_port(ev_port),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [2:0] m_summ();
    logic [2:0] s;
    for (int i = 0; i < 3; i++) s[i] = |(m_stat[i] & ~m_mask[i]);
    return s;
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    if (a < 3) return m_stat[a];
    if (a == 3) return {5'd0, m_summ()};
    if (a < 7) return m_mask[a - 3'd4];
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    if (a < 3) return "R3";
    if (a == 3) return "R7";
    if (a < 7) return "R5";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_stat[i] = '0;
      m_mask[i] = '1;
    end
    m_irq = 1'b0;
  endtask

  task automatic step(input logic [7:0] ea, input logic [7:0] eb, input logic [7:0] ep,
                      input logic rd, input logic wr, input logic [2:0] a,
                      input logic [7:0] wd, input string tag);
    logic [7:0] evs [3];
    @(negedge clk);
    check({tag, "/R8 irq"}, {7'd0, irq}, {7'd0, m_irq});
    ev_ch_a = ea; ev_ch_b = eb; ev_port = ep;
    rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    #1;
    check(tag.len() != 0 ? tag : tag_of(a), rdata, m_read(a));
    evs[0] = ea; evs[1] = eb; evs[2] = ep;
    m_irq = |m_summ();
    for (int i = 0; i < 3; i++) begin
      m_stat[i] = (rd && a == 3'(i)) ? evs[i] : (m_stat[i] | evs[i]);
      if (wr && a == 3'(4 + i)) m_mask[i] = wd;
    end
    @(posedge clk);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values through every address
    for (int a = 0; a < 8; a++) step(0, 0, 0, 1'b0, 1'b0, 3'(a), 0, "R1");
    // R6: masked event latched, no summary, no irq
    step(8'h08, 0, 0, 1'b0, 1'b0, 3'd0, 0, "R6");
    step(0, 0, 0, 1'b0, 1'b0, 3'd3, 0, "R6");
    step(0, 0, 0, 1'b0, 1'b0, 3'd0, 0, "R6");
    // R9: unmask bit 3, summary next cycle, irq after
    step(0, 0, 0, 1'b0, 1'b1, 3'd4, 8'hF7, "R9");
    step(0, 0, 0, 1'b0, 1'b0, 3'd3, 0, "R9");
    step(0, 0, 0, 1'b0, 1'b0, 3'd3, 0, "R9");
    // R4: event meets clearing read
    step(8'h02, 0, 0, 1'b1, 1'b0, 3'd0, 0, "R4");
    step(0, 0, 0, 1'b1, 1'b0, 3'd0, 0, "R4");
    step(0, 0, 0, 1'b0, 1'b0, 3'd0, 0, "R3");
    // R10: writes to read-only addresses ignored
    step(0, 8'h11, 8'h40, 1'b0, 1'b0, 3'd7, 0, "R2");
    for (int a = 0; a < 4; a++) step(0, 0, 0, 1'b0, 1'b1, 3'(a), 8'h00, "R10");
    step(0, 0, 0, 1'b0, 1'b1, 3'd7, 8'hAA, "R10");
    for (int a = 0; a < 7; a++) step(0, 0, 0, 1'b0, 1'b0, 3'(a), 0, "R10");
    // R5/R8: unmask port group, read summary, then clear with read
    step(0, 0, 0, 1'b0, 1'b1, 3'd6, 8'h00, "R5");
    step(0, 0, 0, 1'b0, 1'b0, 3'd6, 0, "R5");
    step(0, 0, 0, 1'b1, 1'b0, 3'd3, 0, "R7");
    step(0, 0, 0, 1'b1, 1'b0, 3'd2, 0, "R3");
    step(0, 0, 0, 1'b0, 1'b0, 3'd3, 0, "R8");
    step(0, 0, 0, 1'b0, 1'b0, 3'd3, 0, "R8");
    // random mix, R2 R3 R5 R7 R8
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ea, eb, ep, wd;
      logic rd, wr;
      logic [2:0] a;
      ea = 8'($urandom & $urandom & $urandom);
      eb = 8'($urandom & $urandom & $urandom);
      ep = 8'($urandom & $urandom & $urandom);
      rd = ($urandom % 4) == 0;
      wr = ($urandom % 6) == 0;
      a  = 3'($urandom);
      wd = 8'($urandom);
      step(ea, eb, ep, rd, wr, a, wd, "");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule